// File: doc/BRIEF.md
# Three-Source Interrupt Controller

This block is the interrupt controller of a small 8-bit processor core. It watches three event sources: an external interrupt pin, a one-cycle overflow pulse from a timer, and a change on the upper nibble of an input port. Each event is recorded in its own sticky flag. Each flag is masked by its own enable bit, and a global enable bit gates all of them. The flags, enables and global enable form one 8-bit control register, which software reads and writes.

The sequencer inside the block has three states. `ST_RUN` is normal execution. `ST_PENDING` raises the request to the instruction sequencer. `ST_SERVICE` covers the time spent in the handler. The transitions are:

- `ST_RUN` goes to `ST_PENDING` when the global enable is set and at least one enabled flag is set.
- `ST_PENDING` goes to `ST_SERVICE` on acknowledge.
- `ST_PENDING` goes back to `ST_RUN` if the condition goes away before the acknowledge arrives.
- `ST_SERVICE` goes to `ST_RUN` on the return-from-interrupt strobe.

On acknowledge the block clears the global enable in hardware and raises a one-cycle stack-push request. It always presents the fixed vector address. The return strobe sets the global enable again. A separate wake output tells a sleep controller that an enabled flag is set, whether or not the global enable is set.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, the control register reads 0x00, and `irq_req`, `push_req` and `wake` are low.
- R2: A rising edge on `ext_pin` sets the external flag (control bit 2). The flag is visible on the read port one cycle after the edge is sampled.
- R3: A `tmr_ovf` pulse sets the timer flag (control bit 1) on the next clock edge.
- R4: The port-change flag (control bit 0) sets on every clock edge where `port_nib` differs from the value captured on the last `port_rd`. It does not set while they match.
- R5: A flag sets on its event even when its enable is clear. A control write replaces flags, enables (bits 6:4 = ext, timer, change) and the global enable (bit 7). A flag event in the same cycle as a write wins over a written 0.
- R6: `irq_req` rises one cycle after the global enable and an enabled flag are both set. It falls again if that condition ends before an acknowledge.
- R7: An `ack` while `irq_req` is high clears the global enable and pulses `push_req` for exactly one cycle. `vec_addr` is always 0x0004.
- R8: Flags stay set through acknowledge and are only cleared by a control write.
- R9: `reti` in the service state sets the global enable and returns the sequencer to run.
- R10: `wake` is high while `asleep` is high and any enabled flag is set, even with the global enable clear. This case does not raise `irq_req`.
- R11: Control bit 3 is reserved. Writes to it are ignored and it reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 1 | External interrupt pin, rising edge active |
| tmr_ovf | input | 1 | Timer overflow pulse |
| port_nib | input | 4 | Upper nibble of the watched input port |
| port_rd | input | 1 | Port read strobe; captures the change reference |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read data |
| ack | input | 1 | Sequencer accepts the pending interrupt |
| reti | input | 1 | Return-from-interrupt strobe |
| asleep | input | 1 | Core is in sleep |
| irq_req | output | 1 | Interrupt request to the sequencer |
| vec_addr | output | 16 | Interrupt vector address |
| push_req | output | 1 | One-cycle request to push the return address |
| wake | output | 1 | Wake request to the sleep controller |

## Verification
The sequencer is driven through three patterns, and each one separates a different behaviour:
- A full take-and-return cycle: edge, request, acknowledge, return. This separates the hardware clear and the re-set of the global enable from the software-owned flags.
- A withdrawn request, where the flags are cleared while the request is high. This separates `ST_PENDING` falling back to `ST_RUN` from a sequencer that latches the request.
- Sleep with the global enable clear. This separates the wake path from the request path.

The flag sources are tried one by one with their enables off. A port read is followed by a steady nibble and then a changed nibble, which separates change detection from level detection. A set event in the same cycle as a clearing write shows which one has precedence.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC        = 3;
    localparam int SRC_EXT     = 2;
    localparam int SRC_TMR     = 1;
    localparam int SRC_CHG     = 0;
    localparam int CTL_GIE     = 7;
    localparam int CTL_EN_LSB  = 4;
    localparam int CTL_FLG_LSB = 0;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_PENDING,
        ST_SERVICE
    } seq_state_t;
endpackage

// File: rtl/irq_change_det.sv
module irq_change_det #(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_pin,
    input  logic [NIB_W-1:0] port_nib,
    input  logic             port_rd,
    output logic             ext_evt,
    output logic             chg_evt
);
    logic             ext_q;
    logic [NIB_W-1:0] ref_q;
    logic [NIB_W-1:0] diff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q <= 1'b0;
            ref_q <= '0;
        end else begin
            ext_q <= ext_pin;
            if (port_rd) ref_q <= port_nib;
        end
    end

    generate
        for (genvar i = 0; i < NIB_W; i++) begin : g_bit
            assign diff[i] = port_nib[i] ^ ref_q[i];
        end
    endgenerate

    assign ext_evt = ext_pin & ~ext_q;
    assign chg_evt = |diff;
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
    import irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [DATA_W-1:0] sw_wdata,
    input  logic [NSRC-1:0]   evt,
    input  logic              clr_gie,
    input  logic              set_gie,
    output logic [NSRC-1:0]   flg,
    output logic [NSRC-1:0]   en,
    output logic              gie,
    output logic [DATA_W-1:0] rdata
);
    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flg[i] <= 1'b0;
                    en[i]  <= 1'b0;
                end else begin
                    if (sw_we) en[i] <= sw_wdata[CTL_EN_LSB + i];
                    if (evt[i])     flg[i] <= 1'b1;
                    else if (sw_we) flg[i] <= sw_wdata[CTL_FLG_LSB + i];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       gie <= 1'b0;
        else if (clr_gie) gie <= 1'b0;
        else if (set_gie) gie <= 1'b1;
        else if (sw_we)   gie <= sw_wdata[CTL_GIE];
    end

    always_comb begin
        rdata = '0;
        rdata[CTL_GIE] = gie;
        rdata[CTL_EN_LSB +: NSRC]  = en;
        rdata[CTL_FLG_LSB +: NSRC] = flg;
    end

    // R7
    gie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_gie |=> !gie);
    // R9
    gie_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_gie && !clr_gie) |=> gie);
    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_we |=> ((flg & $past(flg)) == $past(flg)));
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gie,
    input  logic pend,
    input  logic ack,
    input  logic reti,
    output logic irq_req,
    output logic push_req,
    output logic clr_gie,
    output logic set_gie
);
    seq_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:     if (gie && pend) state_nx = ST_PENDING;
            ST_PENDING: if (ack) state_nx = ST_SERVICE;
                        else if (!(gie && pend)) state_nx = ST_RUN;
            ST_SERVICE: if (reti) state_nx = ST_RUN;
            default:    state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_RUN;
            push_req <= 1'b0;
        end else begin
            state    <= state_nx;
            push_req <= (state == ST_PENDING) && ack;
        end
    end

    always_comb begin
        irq_req = (state == ST_PENDING);
        clr_gie = (state == ST_PENDING) && ack;
        set_gie = (state == ST_SERVICE) && reti;
    end

    // R7
    push_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |=> !push_req);
    // R6
    req_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(gie && pend));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter int                NIB_W    = 4,
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] VEC_ADDR = 16'h0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pin,
    input  logic              tmr_ovf,
    input  logic [NIB_W-1:0]  port_nib,
    input  logic              port_rd,
    input  logic              ctl_we,
    input  logic [DATA_W-1:0] ctl_wdata,
    output logic [DATA_W-1:0] ctl_rdata,
    input  logic              ack,
    input  logic              reti,
    input  logic              asleep,
    output logic              irq_req,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              push_req,
    output logic              wake
);
    logic            ext_evt, chg_evt;
    logic [NSRC-1:0] evt, flg, en;
    logic            gie, clr_gie, set_gie, pend;

    irq_change_det #(.NIB_W(NIB_W)) u_det (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .port_nib(port_nib),
        .port_rd(port_rd), .ext_evt(ext_evt), .chg_evt(chg_evt)
    );

    always_comb begin
        evt = '0;
        evt[SRC_EXT] = ext_evt;
        evt[SRC_TMR] = tmr_ovf;
        evt[SRC_CHG] = chg_evt;
    end

    irq_flag_reg #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .sw_we(ctl_we), .sw_wdata(ctl_wdata),
        .evt(evt), .clr_gie(clr_gie), .set_gie(set_gie),
        .flg(flg), .en(en), .gie(gie), .rdata(ctl_rdata)
    );

    assign pend = |(flg & en);

    irq_seq_fsm u_seq (
        .clk(clk), .rst_n(rst_n), .gie(gie), .pend(pend), .ack(ack),
        .reti(reti), .irq_req(irq_req), .push_req(push_req),
        .clr_gie(clr_gie), .set_gie(set_gie)
    );

    assign vec_addr = VEC_ADDR;
    assign wake     = asleep & pend;

    // R10
    wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (ctl_rdata[CTL_EN_LSB +: NSRC] & ctl_rdata[CTL_FLG_LSB +: NSRC]) != '0);
endmodule

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_pin = 0, tmr_ovf = 0, port_rd = 0, ctl_we = 0;
    logic       ack = 0, reti = 0, asleep = 0;
    logic [3:0] port_nib = '0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_rdata;
    logic       irq_req, push_req, wake;
    logic [15:0] vec_addr;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_ctrl i_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
        .port_nib(port_nib), .port_rd(port_rd), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .ack(ack), .reti(reti),
        .asleep(asleep), .irq_req(irq_req), .vec_addr(vec_addr),
        .push_req(push_req), .wake(wake)
    );

    // behavioural reference model
    int         m_state;  // 0 run, 1 pending, 2 service
    logic [2:0] m_flg, m_en;
    logic       m_gie, m_push, m_extq;
    logic [3:0] m_ref;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_flg = 0; m_en = 0; m_gie = 0;
            m_push = 0; m_extq = 0; m_ref = 0;
        end else begin
            bit cond;
            int nstate;
            cond = m_gie && ((m_en & m_flg) != 0);
            nstate = m_state;
            if (m_state == 0 && cond) nstate = 1;
            else if (m_state == 1) nstate = ack ? 2 : (cond ? 1 : 0);
            else if (m_state == 2 && reti) nstate = 0;
            m_push = (m_state == 1) && ack;
            if (ctl_we) begin
                m_flg = ctl_wdata[2:0];
                m_en  = ctl_wdata[6:4];
            end
            if (ext_pin && !m_extq) m_flg[2] = 1'b1;
            if (tmr_ovf) m_flg[1] = 1'b1;
            if (port_nib != m_ref) m_flg[0] = 1'b1;
            if (m_state == 1 && ack) m_gie = 1'b0;
            else if (m_state == 2 && reti) m_gie = 1'b1;
            else if (ctl_we) m_gie = ctl_wdata[7];
            if (port_rd) m_ref = port_nib;
            m_extq = ext_pin;
            m_state = nstate;
        end
    end

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            chk("R5 ctl_rdata", {8'h0, ctl_rdata}, {8'h0, m_gie, m_en, 1'b0, m_flg});
            chk("R6 irq_req", {15'h0, irq_req}, {15'h0, m_state == 1});
            chk("R7 push_req", {15'h0, push_req}, {15'h0, m_push});
            chk("R7 vec_addr", vec_addr, 16'h0004);
            chk("R10 wake", {15'h0, wake}, {15'h0, asleep && ((m_en & m_flg) != 0)});
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] d);
        tick(); ctl_we = 1; ctl_wdata = d;
        tick(); ctl_we = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick(); #1;
        chk("R1 rdata", {8'h0, ctl_rdata}, 16'h0000);
        chk("R1 irq", {15'h0, irq_req}, 16'h0);
        chk("R1 push", {15'h0, push_req}, 16'h0);
        chk("R1 wake", {15'h0, wake}, 16'h0);

        // R3 timer flag with enable off
        tick(); tmr_ovf = 1;
        tick(); tmr_ovf = 0; #1;
        chk("R3 tmr flag", {8'h0, ctl_rdata}, 16'h0002);
        tick(); #1;
        chk("R5 no req when masked", {15'h0, irq_req}, 16'h0);
        wr(8'h00); #1;
        chk("R5 clear", {8'h0, ctl_rdata}, 16'h0000);

        // R2 external edge, full take and return
        wr(8'hC0);
        ext_pin = 1;
        tick(); #1;
        chk("R2 ext flag", {8'h0, ctl_rdata}, 16'h00C4);
        tick(); #1;
        chk("R6 req up", {15'h0, irq_req}, 16'h1);
        tick(); ack = 1;
        tick(); ack = 0; #1;
        chk("R7 push", {15'h0, push_req}, 16'h1);
        chk("R8 flag kept gie cleared", {8'h0, ctl_rdata}, 16'h0044);
        tick(); #1;
        chk("R7 push single", {15'h0, push_req}, 16'h0);
        tick(); reti = 1;
        tick(); reti = 0; #1;
        chk("R9 gie back", {8'h0, ctl_rdata}, 16'h00C4);
        ctl_we = 1; ctl_wdata = 8'hC0;
        tick(); ctl_we = 0; #1;
        chk("R6 req entered", {15'h0, irq_req}, 16'h1);
        tick(); #1;
        chk("R6 req withdrawn", {15'h0, irq_req}, 16'h0);
        ext_pin = 0;

        // R4 port change
        wr(8'h10);
        port_nib = 4'h5; port_rd = 1;
        tick(); port_rd = 0;
        wr(8'h10); #1;
        chk("R4 clear after read", {8'h0, ctl_rdata}, 16'h0010);
        tick(); #1;
        chk("R4 steady nibble", {8'h0, ctl_rdata}, 16'h0010);
        port_nib = 4'h7;
        tick(); #1;
        chk("R4 change seen", {8'h0, ctl_rdata}, 16'h0011);

        // R10 wake with gie clear
        tick(); asleep = 1; #1;
        chk("R10 wake", {15'h0, wake}, 16'h1);
        chk("R10 no req", {15'h0, irq_req}, 16'h0);
        tick(); asleep = 0;

        // R11 reserved bit
        port_rd = 1;
        tick(); port_rd = 0;
        wr(8'h08); #1;
        chk("R11 reserved", {8'h0, ctl_rdata}, 16'h0000);

        // R5 event beats clearing write
        tick(); ctl_we = 1; ctl_wdata = 8'h00; tmr_ovf = 1;
        tick(); ctl_we = 0; tmr_ovf = 0; #1;
        chk("R5 set wins", {8'h0, ctl_rdata}, 16'h0002);

        repeat (4) tick();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule